// File: doc/BRIEF.md
# Buffered Factory-Program Sequencer

This block models the write controller of a NOR-style flash device while it runs a high-throughput factory programming operation. A caller writes a setup command and then a confirm command. The confirm write's address becomes the anchor address for the whole operation. After a fixed check delay, the sequencer samples the block-lock input and the programming-voltage input. It also checks that the anchor address sits on a buffer boundary. If every check passes, the sequencer accepts a stream of data words.

Each data word is a bus write to the anchor address. The sequencer stores the words one after another in an internal buffer. Once the buffer holds a full load, the sequencer copies it into the block's array model and then spends a programming settle time. After that it takes the next load, which lands at the next buffer position inside the same block. The position wraps back to the start of the block after the block's last word.

A write to any other address ends the operation. Any words already collected are padded with the erased value and committed first. From confirm onward, every read returns the status register, and command codes written during streaming are stored as ordinary data.

Top module: `fbp_seq`

## Requirements
- R1: After reset, reads return array contents (every word 16'hFFFF) and writes other than the setup code 16'h0080 have no effect on the array.
- R2: Setup followed by confirm (16'h00D0) switches reads to status. Status bit 7 (ready) and bit 0 (buffer ready) both read 0 for exactly SETUP_CYC cycles after the confirm edge.
- R3: If the block-lock input is high when the check ends, status bits 4 and 1 are set, bit 7 returns to 1, and the array is not written.
- R4: If the voltage-good input is low when the check ends, status bits 4 and 3 are set, bit 7 returns to 1, and the array is not written.
- R5: If the anchor address has nonzero low log2(BUF_WORDS) bits, status bit 4 is set, bit 7 returns to 1, and the array is not written.
- R6: While streaming, status bit 0 reads 1. Each write to the anchor address is stored as the next buffer word, including words equal to the codes 16'h0070, 16'h00B0 and 16'h00FF.
- R7: When the buffer receives its BUF_WORDS-th word, bit 0 reads 0 for BUF_WORDS+PROG_CYC cycles. During that time the buffer is written into the array, and then bit 0 returns to 1.
- R8: Buffer n of an operation lands at (anchor + n*BUF_WORDS) modulo BLOCK_WORDS, so the position wraps inside the block.
- R9: A write to a non-anchor address ends the operation. A partial buffer is committed with its unfilled words set to 16'hFFFF, taking the same busy time as R7. An empty buffer ends the operation at once. Afterwards status reads 16'h0080.
- R10: Bus writes during the check delay or a commit, including the suspend code 16'h00B0, are ignored.
- R11: In the status state, writing 16'h00FF returns reads to the array, and writing 16'h0080 starts a new setup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read enable; read data is zero when low |
| bus_addr | input | AW | Word address within the block |
| bus_wdata | input | 16 | Write data or command code |
| bus_rdata | output | 16 | Array word or zero-extended status |
| blk_locked | input | 1 | Target block lock state |
| vpp_ok | input | 1 | Programming voltage in range |

## Verification
The hardest state to reach is a padded partial buffer committed after the position counter has wrapped. Reaching it takes a full load streamed from the block's upper half, the busy window that follows it, and then a short load ended by a stray address. The bench anchors the operation in the upper half, streams one complete buffer and a partial one, and ends with an exit write. It then reads back the whole block, so that the wrapped placement and the 16'hFFFF padding are both visible at the ports.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
    localparam int DATA_W = 16;

    localparam logic [DATA_W-1:0] CMD_SETUP   = 16'h0080;
    localparam logic [DATA_W-1:0] CMD_CONFIRM = 16'h00D0;
    localparam logic [DATA_W-1:0] CMD_ARRAY   = 16'h00FF;
    localparam logic [DATA_W-1:0] ERASED_WORD = 16'hFFFF;

    typedef enum logic [2:0] {
        ST_ARRAY,
        ST_SETUP,
        ST_CHECK,
        ST_STREAM,
        ST_COMMIT,
        ST_STATUS
    } fbp_state_e;

    typedef struct packed {
        logic       rdy;
        logic [1:0] rsv_hi;
        logic       err;
        logic       vpp_bad;
        logic       rsv_lo;
        logic       locked;
        logic       buf_rdy;
    } fbp_status_t;

    typedef struct packed {
        logic err;
        logic vpp_bad;
        logic locked;
    } fbp_flags_t;

    function automatic logic shows_ready(input fbp_state_e s);
        return (s == ST_ARRAY) || (s == ST_SETUP) || (s == ST_STATUS);
    endfunction
endpackage

// File: rtl/fbp_buffer.sv
module fbp_buffer #(
    parameter int DW    = 16,
    parameter int DEPTH = 512,
    localparam int BW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [BW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [BW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/fbp_array.sv
module fbp_array #(
    parameter int DW    = 16,
    parameter int WORDS = 1024,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) cells[i] <= '1;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/fbp_ctrl.sv
module fbp_ctrl
    import fbp_pkg::*;
#(
    parameter int AW        = 10,
    parameter int BUF_WORDS = 512,
    parameter int SETUP_CYC = 8,
    parameter int PROG_CYC  = 4,
    localparam int BW       = $clog2(BUF_WORDS),
    localparam int CW       = $clog2(BUF_WORDS + PROG_CYC + SETUP_CYC + 1) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              blk_locked,
    input  logic              vpp_ok,
    output fbp_state_e        state,
    output fbp_status_t       sr,
    output logic              buf_we,
    output logic [BW-1:0]     buf_waddr,
    output logic [BW-1:0]     buf_raddr,
    output logic              arr_we,
    output logic [AW-1:0]     arr_waddr,
    output logic              pad
);
    localparam logic [CW-1:0] SETUP_LAST  = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] COMMIT_LAST = CW'(BUF_WORDS + PROG_CYC - 1);
    localparam logic [CW-1:0] COPY_END    = CW'(BUF_WORDS);
    localparam logic [BW:0]   FILL_LAST   = (BW+1)'(BUF_WORDS - 1);

    logic [AW-1:0] anchor;
    logic [AW-1:0] base;
    logic [BW:0]   fill;
    logic [CW-1:0] tcnt;
    logic          exit_pend;
    fbp_flags_t    flags;

    logic anchor_hit;
    logic misaligned;
    assign anchor_hit = bus_we && (bus_addr == anchor);
    assign misaligned = anchor[BW-1:0] != '0;

    assign buf_we    = (state == ST_STREAM) && anchor_hit;
    assign buf_waddr = fill[BW-1:0];
    assign buf_raddr = tcnt[BW-1:0];
    assign arr_we    = (state == ST_COMMIT) && (tcnt < COPY_END);
    assign arr_waddr = base + AW'(tcnt[BW-1:0]);
    assign pad       = tcnt >= CW'(fill);

    always_comb begin
        sr         = '0;
        sr.rdy     = shows_ready(state);
        sr.buf_rdy = (state == ST_STREAM);
        sr.err     = flags.err;
        sr.vpp_bad = flags.vpp_bad;
        sr.locked  = flags.locked;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_ARRAY;
            anchor    <= '0;
            base      <= '0;
            fill      <= '0;
            tcnt      <= '0;
            exit_pend <= 1'b0;
            flags     <= '0;
        end else begin
            unique case (state)
                ST_ARRAY: begin
                    if (bus_we && bus_wdata == CMD_SETUP) state <= ST_SETUP;
                end
                ST_SETUP: begin
                    if (bus_we) begin
                        if (bus_wdata == CMD_CONFIRM) begin
                            anchor <= bus_addr;
                            flags  <= '0;
                            tcnt   <= '0;
                            state  <= ST_CHECK;
                        end else begin
                            state <= ST_ARRAY;
                        end
                    end
                end
                ST_CHECK: begin
                    tcnt <= tcnt + 1'b1;
                    if (tcnt == SETUP_LAST) begin
                        flags.locked  <= blk_locked;
                        flags.vpp_bad <= !vpp_ok;
                        flags.err     <= blk_locked || !vpp_ok || misaligned;
                        base          <= anchor;
                        fill          <= '0;
                        state <= (blk_locked || !vpp_ok || misaligned) ? ST_STATUS
                                                                         : ST_STREAM;
                    end
                end
                ST_STREAM: begin
                    if (bus_we) begin
                        tcnt <= '0;
                        if (anchor_hit) begin
                            fill <= fill + 1'b1;
                            if (fill == FILL_LAST) begin
                                exit_pend <= 1'b0;
                                state     <= ST_COMMIT;
                            end
                        end else if (fill == '0) begin
                            state <= ST_STATUS;
                        end else begin
                            exit_pend <= 1'b1;
                            state     <= ST_COMMIT;
                        end
                    end
                end
                ST_COMMIT: begin
                    tcnt <= tcnt + 1'b1;
                    if (tcnt == COMMIT_LAST) begin
                        base  <= base + AW'(BUF_WORDS);
                        fill  <= '0;
                        state <= exit_pend ? ST_STATUS : ST_STREAM;
                    end
                end
                ST_STATUS: begin
                    if (bus_we && bus_wdata == CMD_SETUP)      state <= ST_SETUP;
                    else if (bus_we && bus_wdata == CMD_ARRAY) state <= ST_ARRAY;
                end
                default: state <= ST_ARRAY;
            endcase
        end
    end
endmodule

// File: rtl/fbp_seq.sv
module fbp_seq
    import fbp_pkg::*;
#(
    parameter int BLOCK_WORDS = 1024,
    parameter int BUF_WORDS   = 512,
    parameter int SETUP_CYC   = 8,
    parameter int PROG_CYC    = 4,
    localparam int AW         = $clog2(BLOCK_WORDS),
    localparam int BW         = $clog2(BUF_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic              bus_rd,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              blk_locked,
    input  logic              vpp_ok
);
    fbp_state_e    state;
    fbp_status_t   sr;
    logic          buf_we;
    logic [BW-1:0] buf_waddr;
    logic [BW-1:0] buf_raddr;
    logic          arr_we;
    logic [AW-1:0] arr_waddr;
    logic          pad;
    logic [DATA_W-1:0] buf_rdata;
    logic [DATA_W-1:0] arr_wdata;
    logic [DATA_W-1:0] arr_rdata;

    fbp_ctrl #(
        .AW(AW), .BUF_WORDS(BUF_WORDS), .SETUP_CYC(SETUP_CYC), .PROG_CYC(PROG_CYC)
    ) u_ctrl (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .blk_locked(blk_locked), .vpp_ok(vpp_ok),
        .state(state), .sr(sr), .buf_we(buf_we), .buf_waddr(buf_waddr),
        .buf_raddr(buf_raddr), .arr_we(arr_we), .arr_waddr(arr_waddr), .pad(pad)
    );

    fbp_buffer #(.DW(DATA_W), .DEPTH(BUF_WORDS)) u_buf (
        .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(bus_wdata),
        .raddr(buf_raddr), .rdata(buf_rdata)
    );

    assign arr_wdata = pad ? ERASED_WORD : buf_rdata;

    fbp_array #(.DW(DATA_W), .WORDS(BLOCK_WORDS)) u_arr (
        .clk(clk), .rst(rst), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
        .raddr(bus_addr), .rdata(arr_rdata)
    );

    always_comb begin
        if (!bus_rd)                bus_rdata = '0;
        else if (state == ST_ARRAY) bus_rdata = arr_rdata;
        else                        bus_rdata = DATA_W'(sr);
    end
endmodule

// File: rtl/fbp_checker.sv
module fbp_checker (
    input logic clk,
    input logic rst,
    input logic rdy,
    input logic err,
    input logic vpp_bad,
    input logic locked,
    input logic buf_rdy,
    input logic arr_we,
    input logic buf_we
);
    assert_ready_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
        buf_rdy |-> !rdy);

    assert_lock_flag_R3: assert property (@(posedge clk) disable iff (rst)
        locked |-> (err && rdy));

    assert_vpp_flag_R4: assert property (@(posedge clk) disable iff (rst)
        vpp_bad |-> (err && rdy));

    assert_no_prog_on_error_R5: assert property (@(posedge clk) disable iff (rst)
        err |-> !arr_we);

    assert_load_when_ready_R6: assert property (@(posedge clk) disable iff (rst)
        buf_we |-> buf_rdy);

    assert_prog_while_busy_R7: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> (!buf_rdy && !rdy));

    assert_no_load_while_prog_R10: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> !buf_we);
endmodule

bind fbp_seq fbp_checker u_chk (
    .clk(clk), .rst(rst), .rdy(sr.rdy), .err(sr.err), .vpp_bad(sr.vpp_bad),
    .locked(sr.locked), .buf_rdy(sr.buf_rdy), .arr_we(arr_we), .buf_we(buf_we)
);

// File: tb/fbp_seq_tb.sv
`timescale 1ns/1ps
module fbp_seq_tb;
    localparam int BLK   = 1024;
    localparam int BUFW  = 512;
    localparam int SETUP = 8;
    localparam int PROG  = 4;
    localparam int AW    = 10;

    localparam int M_ARRAY = 0, M_SETUP = 1, M_CHECK = 2, M_STREAM = 3,
                   M_COMMIT = 4, M_STATUS = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_we = 1'b0;
    logic          bus_rd = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic [15:0]   bus_wdata = '0;
    logic [15:0]   bus_rdata;
    logic          blk_locked = 1'b0;
    logic          vpp_ok = 1'b1;

    always #2 clk = ~clk;

    fbp_seq u_dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .blk_locked(blk_locked), .vpp_ok(vpp_ok)
    );

    int checks = 0;
    int errors = 0;
    string cur_tag = "R1";

    // behavioural reference state
    logic [15:0] mmem [BLK];
    logic [15:0] mq [$];
    int mst, mwa0, mbase, mtimer;
    bit mexit, f_err, f_vpp, f_lock;

    function automatic logic [15:0] model_rdata(input int a);
        logic [7:0] s;
        if (mst == M_ARRAY) return mmem[a];
        s = 8'h00;
        s[7] = (mst == M_ARRAY) || (mst == M_SETUP) || (mst == M_STATUS);
        s[0] = (mst == M_STREAM);
        s[4] = f_err;
        s[3] = f_vpp;
        s[1] = f_lock;
        return {8'h00, s};
    endfunction

    task automatic start_commit(input bit ex);
        for (int i = 0; i < BUFW; i++)
            mmem[(mbase + i) % BLK] = (i < mq.size()) ? mq[i] : 16'hFFFF;
        mbase  = (mbase + BUFW) % BLK;
        mq.delete();
        mtimer = BUFW + PROG;
        mexit  = ex;
        mst    = M_COMMIT;
    endtask

    task automatic model_step(input bit w, input int a, input logic [15:0] d);
        case (mst)
            M_ARRAY: if (w && d == 16'h0080) mst = M_SETUP;
            M_SETUP: if (w) begin
                if (d == 16'h00D0) begin
                    mwa0 = a; f_err = 0; f_vpp = 0; f_lock = 0;
                    mtimer = SETUP; mst = M_CHECK;
                end else mst = M_ARRAY;
            end
            M_CHECK: begin
                mtimer--;
                if (mtimer == 0) begin
                    f_lock = blk_locked;
                    f_vpp  = !vpp_ok;
                    f_err  = blk_locked || !vpp_ok || ((mwa0 % BUFW) != 0);
                    mbase  = mwa0;
                    mq.delete();
                    mst = f_err ? M_STATUS : M_STREAM;
                end
            end
            M_STREAM: if (w) begin
                if (a == mwa0) begin
                    mq.push_back(d);
                    if (mq.size() == BUFW) start_commit(1'b0);
                end else if (mq.size() == 0) mst = M_STATUS;
                else start_commit(1'b1);
            end
            M_COMMIT: begin
                mtimer--;
                if (mtimer == 0) mst = mexit ? M_STATUS : M_STREAM;
            end
            M_STATUS: if (w) begin
                if (d == 16'h0080) mst = M_SETUP;
                else if (d == 16'h00FF) mst = M_ARRAY;
            end
            default: mst = M_ARRAY;
        endcase
    endtask

    task automatic cyc(input bit w, input int a, input logic [15:0] d);
        logic [15:0] exp;
        bus_we = w; bus_addr = AW'(a); bus_wdata = d;
        #1;
        exp = model_rdata(a);
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s addr=%0h actual=%h expected=%h", cur_tag, a, bus_rdata, exp);
        end
        @(posedge clk);
        model_step(w, a, d);
        @(negedge clk);
    endtask

    task automatic idle(input int n, input int a);
        for (int i = 0; i < n; i++) cyc(1'b0, a, 16'h0000);
    endtask

    task automatic start_op(input int a);
        cyc(1'b1, a, 16'h0080);
        cyc(1'b1, a, 16'h00D0);
    endtask

    function automatic logic [15:0] pat1(input int i);
        if (i == 3) return 16'h0070;
        if (i == 4) return 16'h00B0;
        if (i == 5) return 16'h00FF;
        return 16'(i * 3 + 16'h1000);
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        for (int i = 0; i < BLK; i++) mmem[i] = 16'hFFFF;
        mst = M_ARRAY; mwa0 = 0; mbase = 0; mtimer = 0;
        mexit = 0; f_err = 0; f_vpp = 0; f_lock = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: erased array after reset, stray writes ignored
        cur_tag = "R1";
        idle(4, 0);
        cyc(1'b1, 7, 16'h1234);
        idle(2, 7);
        idle(2, 1023);

        // R5: misaligned anchor; R2 check window observed
        cur_tag = "R2";
        start_op(5);
        idle(SETUP - 1, 5);
        cur_tag = "R5";
        idle(3, 5);
        cur_tag = "R11";
        cyc(1'b1, 0, 16'h00FF);
        idle(2, 5);

        // R3: locked block
        cur_tag = "R3";
        blk_locked = 1'b1;
        start_op(0);
        idle(SETUP + 2, 0);
        cyc(1'b1, 0, 16'h00FF);
        idle(1, 0);
        blk_locked = 1'b0;

        // R4: bad voltage
        cur_tag = "R4";
        vpp_ok = 1'b0;
        start_op(0);
        idle(SETUP + 2, 0);
        vpp_ok = 1'b1;
        // R11: setup straight from status mode
        cur_tag = "R11";
        start_op(512);
        // R10: writes during check ignored
        cur_tag = "R10";
        for (int i = 0; i < SETUP; i++) cyc(1'b1, (i % 2) ? 512 : 3, 16'h00B0);
        idle(1, 512);

        // R6: full buffer including command-like data
        cur_tag = "R6";
        for (int i = 0; i < BUFW; i++) cyc(1'b1, 512, pat1(i));
        // R7/R10: commit busy window with ignored writes
        cur_tag = "R10";
        for (int i = 0; i < 4; i++) cyc(1'b1, 512, 16'h00B0);
        cur_tag = "R7";
        idle(BUFW + PROG - 4 + 2, 512);

        // R8: second buffer wraps to block start; R9 partial + exit
        cur_tag = "R8";
        for (int i = 0; i < 100; i++) cyc(1'b1, 512, 16'(16'hA000 + i));
        cur_tag = "R9";
        cyc(1'b1, 1023, 16'h0000);
        idle(BUFW + PROG + 3, 0);
        cur_tag = "R11";
        cyc(1'b1, 0, 16'h00FF);
        cur_tag = "R8";
        for (int i = 0; i < BLK; i++) cyc(1'b0, i, 16'h0000);

        // R9: empty-buffer exit leaves array untouched
        cur_tag = "R9";
        start_op(0);
        idle(SETUP, 0);
        cyc(1'b1, 9, 16'h0000);
        idle(3, 0);
        cyc(1'b1, 0, 16'h00FF);
        for (int i = 0; i < 8; i++) cyc(1'b0, i * 97, 16'h0000);

        // bus_rd low gives zero
        cur_tag = "R1";
        bus_rd = 1'b0;
        bus_addr = '0;
        #1;
        checks++;
        if (bus_rdata !== 16'h0000) begin
            errors++;
            $display("FAIL R1 rd-disabled actual=%h expected=0000", bus_rdata);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule